// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers completion strobes from up to sixteen DMA channels and turns them into sticky pending flags that software reads and clears over a simple register bus. Each channel reports three kinds of event: half of the transfer done, one package done and the whole queue done. Each flag can be enabled on its own. Every set flag feeds one registered interrupt line.

Channels are packed four bits per channel into two 32-bit banks. Channels 0 to 7 live in the first bank and channels 8 to 15 in the second. Each bank has an enable word and a pending word. A summary word shows, one bit per channel, which channels hold any pending event. Reads are combinational from the current address. Writes take effect on the rising clock edge while the write strobe is high.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every enable word, every pending word, the summary word and the interrupt output are zero.
- R2: Event kind k of channel n maps to bit (n mod 8)*4+k of bank n/8, where k=0 is half-done, k=1 is package-done and k=2 is queue-done. Bank 0 pending sits at offset 0x10 and bank 1 at 0x14; bank 0 enable sits at 0x00 and bank 1 at 0x04. In the 64-bit view {bank1, bank0}, the channel of a pending bit is its index divided by 4.
- R3: An event strobe sets its pending bit on the next clock edge only when the matching enable bit already holds 1; with the enable at 0 the strobe has no effect.
- R4: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged; writing all ones clears the whole bank.
- R5: An event strobe in the same cycle as a write of 1 to its pending bit leaves that bit set.
- R6: Clearing an enable bit leaves an already pending bit set; pending bits change to 0 only through writes to a pending word.
- R7: The interrupt output is high exactly when the pending bits held one cycle earlier were not all zero. It rises one cycle after the first bit is set and falls one cycle after the last bit is cleared.
- R8: Bit 3 of every nibble, and every bit of a channel at or above the configured channel count, reads 0 in both enable and pending words and cannot be set.
- R9: The summary word at offset 0x30 holds, in bit n, the OR of channel n's pending nibble. Its other bits read 0.
- R10: Any offset other than 0x00, 0x04, 0x10, 0x14 and 0x30 reads 0, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Register byte offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| evHalf | input | NUM_CH | Half-done strobes, one per channel |
| evPkg | input | NUM_CH | Package-done strobes, one per channel |
| evQueue | input | NUM_CH | Queue-done strobes, one per channel |
| irqOut | output | 1 | Combined interrupt, registered |

## Verification
The bench builds two copies side by side. The first uses the default sixteen channels, so both banks are fully populated, and the nibble mapping can be driven at the edges of both banks (channels 0, 7, 8 and 15). The second uses twelve channels, which leaves the upper half of bank 1 unpopulated. This brings within reach the check that writes of all ones to the enables of absent channels never stick. Both copies share the register bus, so one write sequence exercises the full and the partial configuration at once.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;

  localparam int REG_W       = 32;
  localparam int NIB_W       = 4;
  localparam int CH_PER_BANK = REG_W / NIB_W;
  localparam int NUM_BANKS   = 2;
  localparam int MAX_CH      = CH_PER_BANK * NUM_BANKS;
  localparam int VEC_W       = REG_W * NUM_BANKS;
  localparam int KINDS       = 3;

  // register offsets
  localparam logic [7:0] OFS_EN0 = 8'h00;
  localparam logic [7:0] OFS_EN1 = 8'h04;
  localparam logic [7:0] OFS_PD0 = 8'h10;
  localparam logic [7:0] OFS_PD1 = 8'h14;
  localparam logic [7:0] OFS_STA = 8'h30;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_EN0,
    RD_EN1,
    RD_PD0,
    RD_PD1,
    RD_STA
  } rdSel_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] enWr;
    logic [NUM_BANKS-1:0] pendClr;
    rdSel_e               rdSel;
  } ctrlStrobe_t;

  // bits that exist for a given channel count
  function automatic logic [VEC_W-1:0] validMask(input int numCh);
    logic [VEC_W-1:0] m;
    m = '0;
    for (int ch = 0; ch < MAX_CH; ch++) begin
      for (int k = 0; k < KINDS; k++) begin
        if (ch < numCh) m[ch*NIB_W+k] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobes
);

  localparam logic [ADDR_W-1:0] A_EN0 = ADDR_W'(OFS_EN0);
  localparam logic [ADDR_W-1:0] A_EN1 = ADDR_W'(OFS_EN1);
  localparam logic [ADDR_W-1:0] A_PD0 = ADDR_W'(OFS_PD0);
  localparam logic [ADDR_W-1:0] A_PD1 = ADDR_W'(OFS_PD1);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(OFS_STA);

  rdSel_e sel;

  always_comb begin
    case (regAddr)
      A_EN0:   sel = RD_EN0;
      A_EN1:   sel = RD_EN1;
      A_PD0:   sel = RD_PD0;
      A_PD1:   sel = RD_PD1;
      A_STA:   sel = RD_STA;
      default: sel = RD_NONE;
    endcase
  end

  always_comb begin
    strobes.rdSel      = sel;
    strobes.enWr[0]    = regWrEn && (sel == RD_EN0);
    strobes.enWr[1]    = regWrEn && (sel == RD_EN1);
    strobes.pendClr[0] = regWrEn && (sel == RD_PD0);
    strobes.pendClr[1] = regWrEn && (sel == RD_PD1);
  end

endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_agg_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic [REG_W-1:0]  wrData,
  input  logic [NUM_CH-1:0] evHalf,
  input  logic [NUM_CH-1:0] evPkg,
  input  logic [NUM_CH-1:0] evQueue,
  output logic [REG_W-1:0]  rdData,
  output logic [VEC_W-1:0]  enVec,
  output logic [VEC_W-1:0]  pendVec,
  output logic              irqOut
);

  localparam logic [VEC_W-1:0] VALID = validMask(NUM_CH);

  logic [VEC_W-1:0]  evVec;
  logic [MAX_CH-1:0] chBusy;
  logic              irqReg;

  // spread strobes into the nibble layout; absent channels stay at zero
  for (genvar ch = 0; ch < MAX_CH; ch++) begin : g_nib
    if (ch < NUM_CH) begin : g_live
      assign evVec[ch*NIB_W+0] = evHalf[ch];
      assign evVec[ch*NIB_W+1] = evPkg[ch];
      assign evVec[ch*NIB_W+2] = evQueue[ch];
    end else begin : g_dead
      assign evVec[ch*NIB_W+2:ch*NIB_W] = '0;
    end
    assign evVec[ch*NIB_W+3] = 1'b0;
    assign chBusy[ch] = |pendVec[ch*NIB_W +: NIB_W];
  end

  // one enable/pending pair per bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [REG_W-1:0] enReg;
    logic [REG_W-1:0] pendReg;
    logic [REG_W-1:0] clrMask;

    assign clrMask = strobes.pendClr[b] ? wrData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg   <= '0;
        pendReg <= '0;
      end else begin
        if (strobes.enWr[b]) enReg <= wrData & VALID[b*REG_W +: REG_W];
        pendReg <= (pendReg & ~clrMask) | (evVec[b*REG_W +: REG_W] & enReg);
      end
    end

    assign enVec[b*REG_W +: REG_W]   = enReg;
    assign pendVec[b*REG_W +: REG_W] = pendReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqReg <= 1'b0;
    else       irqReg <= |pendVec;
  end
  assign irqOut = irqReg;

  always_comb begin
    case (strobes.rdSel)
      RD_EN0:  rdData = enVec[REG_W-1:0];
      RD_EN1:  rdData = enVec[VEC_W-1:REG_W];
      RD_PD0:  rdData = pendVec[REG_W-1:0];
      RD_PD1:  rdData = pendVec[VEC_W-1:REG_W];
      RD_STA:  rdData = {{(REG_W-MAX_CH){1'b0}}, chBusy};
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_agg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [NUM_CH-1:0] evHalf,
  input  logic [NUM_CH-1:0] evPkg,
  input  logic [NUM_CH-1:0] evQueue,
  output logic              irqOut
);

  ctrlStrobe_t      strobes;
  logic [VEC_W-1:0] enVec;
  logic [VEC_W-1:0] pendVec;

  dma_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  dma_irq_datapath #(.NUM_CH(NUM_CH)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (regWrData),
    .evHalf  (evHalf),
    .evPkg   (evPkg),
    .evQueue (evQueue),
    .rdData  (regRdData),
    .enVec   (enVec),
    .pendVec (pendVec),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk
  import dma_irq_agg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [REG_W-1:0]  regRdData,
  input logic              irqOut,
  input logic [VEC_W-1:0]  enVec,
  input logic [VEC_W-1:0]  pendVec
);

  localparam logic [VEC_W-1:0] VALID = validMask(NUM_CH);

  function automatic logic [REG_W-1:0] busyWord(input logic [VEC_W-1:0] p);
    logic [REG_W-1:0] w;
    w = '0;
    for (int ch = 0; ch < MAX_CH; ch++) w[ch] = |p[ch*NIB_W +: NIB_W];
    return w;
  endfunction

  logic pendWrite;
  assign pendWrite = regWrEn &&
                     (regAddr == ADDR_W'(OFS_PD0) || regAddr == ADDR_W'(OFS_PD1));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !irqOut);

  // R3
  set_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ~$past(pendVec) & ~$past(enVec)) == '0));

  // R6
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendWrite |=> ((pendVec & $past(pendVec)) == $past(pendVec)));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|pendVec) |=> irqOut);

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|pendVec) |=> !irqOut);

  // R8
  no_ghost_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((enVec & ~VALID) == '0) && ((pendVec & ~VALID) == '0));

  // R9
  summary_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFS_STA)) |-> (regRdData == busyWord(pendVec)));

endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .enVec     (enVec),
  .pendVec   (pendVec)
);

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = 8'h3c;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rd16, rd12;
  logic [15:0] h16 = '0, p16 = '0, q16 = '0;
  logic [11:0] h12 = '0, p12 = '0, q12 = '0;
  logic        irq16, irq12;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  dma_irq_agg dut_i (
    .clk(clk), .rstN(rstN), .regAddr(addr), .regWrEn(wrEn), .regWrData(wrData),
    .regRdData(rd16), .evHalf(h16), .evPkg(p16), .evQueue(q16), .irqOut(irq16)
  );

  dma_irq_agg #(.NUM_CH(12)) dut12_i (
    .clk(clk), .rstN(rstN), .regAddr(addr), .regWrEn(wrEn), .regWrData(wrData),
    .regRdData(rd12), .evHalf(h12), .evPkg(p12), .evQueue(q12), .irqOut(irq12)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = 8'h3c;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #2;
    v = rd16;
  endtask

  task automatic pulse(input logic [15:0] h, input logic [15:0] p, input logic [15:0] q);
    @(negedge clk);
    h16 = h; p16 = p; q16 = q;
    @(negedge clk);
    h16 = '0; p16 = '0; q16 = '0;
  endtask

  // R2: bank and bit of event kind k on channel ch
  function automatic logic [7:0] pendOfs(input int ch);
    return (ch < 8) ? 8'h10 : 8'h14;
  endfunction
  function automatic logic [31:0] bitOf(input int ch, input int k);
    return 32'h1 << ((ch % 8) * 4 + k);
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R1", "enable bank0", v, 32'h0);
    rd(8'h04, v); chk("R1", "enable bank1", v, 32'h0);
    rd(8'h10, v); chk("R1", "pending bank0", v, 32'h0);
    rd(8'h14, v); chk("R1", "pending bank1", v, 32'h0);
    rd(8'h30, v); chk("R1", "summary", v, 32'h0);
    chk("R1", "irq", {31'b0, irq16}, 32'h0);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    pulse(16'hffff, 16'hffff, 16'hffff);
    rd(8'h10, v); chk("R3", "bank0 with enables off", v, 32'h0);
    rd(8'h14, v); chk("R3", "bank1 with enables off", v, 32'h0);
    @(negedge clk);
    chk("R3", "irq with enables off", {31'b0, irq16}, 32'h0);
  endtask

  task automatic t_masks;
    logic [31:0] v;
    wr(8'h00, 32'hffffffff);
    wr(8'h04, 32'hffffffff);
    rd(8'h00, v); chk("R8", "enable bank0 nibble bit3", v, 32'h77777777);
    rd(8'h04, v); chk("R8", "enable bank1 nibble bit3", v, 32'h77777777);
    addr = 8'h04; #2;
    chk("R8", "12-channel bank1 enables", rd12, 32'h00007777);
    addr = 8'h3c;
  endtask

  task automatic t_mapping;
    int chans[4] = '{0, 7, 8, 15};
    logic [31:0] v;
    foreach (chans[i]) begin
      for (int k = 0; k < 3; k++) begin
        logic [15:0] m;
        m = 16'h1 << chans[i];
        pulse(k == 0 ? m : 16'h0, k == 1 ? m : 16'h0, k == 2 ? m : 16'h0);
        rd(pendOfs(chans[i]), v);
        chk("R2", $sformatf("ch%0d kind%0d bit", chans[i], k), v, bitOf(chans[i], k));
        chk("R7", "irq one cycle late", {31'b0, irq16}, 32'h0);
        @(negedge clk);
        chk("R7", "irq risen", {31'b0, irq16}, 32'h1);
        wr(pendOfs(chans[i]), 32'hffffffff);
        rd(pendOfs(chans[i]), v);
        chk("R4", "all ones clears", v, 32'h0);
        chk("R7", "irq held one cycle", {31'b0, irq16}, 32'h1);
        @(negedge clk);
        chk("R7", "irq fallen", {31'b0, irq16}, 32'h0);
      end
    end
    // 64-bit view: pkg events on ch2 and ch10 land at bits 9 and 41
    pulse(16'h0, 16'h0404, 16'h0);
    begin
      logic [31:0] lo, hi;
      logic [63:0] view;
      int first;
      rd(8'h10, lo); rd(8'h14, hi);
      view = {hi, lo};
      first = -1;
      for (int b = 63; b >= 0; b--) if (view[b]) first = b;
      chk("R2", "64-bit view", view[63:32] ^ view[31:0], 32'h00000200 ^ 32'h00000200);
      chk("R2", "lowest pkg bit channel", 32'(first / 4), 32'd2);
      chk("R2", "view bit 41", {31'b0, view[41]}, 32'h1);
    end
    wr(8'h10, 32'hffffffff);
    wr(8'h14, 32'hffffffff);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    pulse(16'h00ff, 16'h00ff, 16'h0000);
    rd(8'h10, v); chk("R4", "set before partial clear", v, 32'h33333333);
    wr(8'h10, 32'h0000000f);
    rd(8'h10, v); chk("R4", "partial clear", v, 32'h33333330);
    wr(8'h10, 32'h0);
    rd(8'h10, v); chk("R4", "zero write keeps bits", v, 32'h33333330);
    wr(8'h10, 32'hffffffff);
    rd(8'h10, v); chk("R4", "bank cleared", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    pulse(16'h0, 16'h0010, 16'h0);
    @(negedge clk);
    p16 = 16'h0010; addr = 8'h10; wrData = 32'h00020000; wrEn = 1'b1;
    @(negedge clk);
    p16 = '0; wrEn = 1'b0; addr = 8'h3c;
    rd(8'h10, v); chk("R5", "event beats clear", v, 32'h00020000);
    wr(8'h10, 32'h00020000);
    rd(8'h10, v); chk("R5", "plain clear afterwards", v, 32'h0);
  endtask

  task automatic t_enable_drop;
    logic [31:0] v;
    pulse(16'h0000, 16'h0000, 16'h0200);
    wr(8'h04, 32'h0);
    rd(8'h14, v); chk("R6", "pending kept after enable off", v, 32'h00000040);
    @(negedge clk);
    chk("R6", "irq kept", {31'b0, irq16}, 32'h1);
    wr(8'h14, 32'hffffffff);
    wr(8'h04, 32'hffffffff);
  endtask

  task automatic t_summary;
    logic [31:0] v;
    pulse(16'h0008, 16'h0000, 16'h0200);
    rd(8'h30, v); chk("R9", "summary ch3 and ch9", v, 32'h00000208);
    wr(8'h10, 32'hffffffff);
    rd(8'h30, v); chk("R9", "summary after bank0 clear", v, 32'h00000200);
    wr(8'h14, 32'hffffffff);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    pulse(16'h0001, 16'h0, 16'h0);
    wr(8'h08, 32'hffffffff);
    wr(8'h20, 32'hffffffff);
    rd(8'h20, v); chk("R10", "unmapped read", v, 32'h0);
    rd(8'h10, v); chk("R10", "pending untouched", v, 32'h00000001);
    rd(8'h00, v); chk("R10", "enable untouched", v, 32'h77777777);
    wr(8'h10, 32'hffffffff);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_masks();
    t_mapping();
    t_w1c();
    t_collide();
    t_enable_drop();
    t_summary();
    t_unmapped();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule